// File: doc/BRIEF.md
# Debounced Single-Shot Fire Trigger with Combinational Veto

This block makes the final go/no-go decision for one shot. While it is armed, it counts the clock cycles in which a phase-lock indication stays high without a break. It qualifies the lock once that run reaches `LOCK_HOLD_CYCLES` cycles. It then emits a single one-cycle fire strobe and latches that the shot is spent. Once the shot is spent, no further fire can occur until the block is reset or armed again.

A second path is a registerless gate between the qualified request and the fire pin. It passes the request only while a permit input is high and no safety veto is present. This path can only take a fire away, and it acts in the same cycle it is asserted. A veto seen during qualification also restarts the lock run.

All pins are plain control and status. No data stream crosses the block, so it has no valid/ready handshake and no back-pressure. Reset is synchronous and active high.

Top module: `shot_trigger`

## Requirements
- R1: When reset is asserted (`rst`=1), the next cycle shows count 0, fire 0, done 0 and lock_now 0, and the block is not armed.
- R2: While armed, `fire_o` goes high combinationally in the cycle where `lock_i` is high for the LOCK_HOLD_CYCLES-th consecutive cycle, provided `permit_i`=1 and `veto_i`=0. `fire_o` stays high for that one cycle only.
- R3: A lock run that is one cycle shorter than LOCK_HOLD_CYCLES produces no fire. `count_o` reports, as an unsigned binary value, the number of consecutive qualifying cycles already seen.
- R4: Any armed cycle with `lock_i`=0 clears the count to 0 at the next edge, so a broken run must start over.
- R5: Whenever `veto_i`=1, `fire_o`=0 in that same cycle, whatever the count. A vetoed cycle also clears the count, so a new full run is needed.
- R6: With `permit_i`=0, `fire_o` stays 0. `lock_now_o` still reports the qualified condition, and the count saturates at LOCK_HOLD_CYCLES without wrapping. Raising the permit while lock holds fires in that cycle.
- R7: After a fire, `done_o`=1 from the next cycle on. No further fire occurs, and the count stays 0, until an arm or a reset.
- R8: A high `arm_i` while idle or done arms the block at the next edge and clears `done_o`.
- R9: While not armed, the count stays 0 and `fire_o` and `lock_now_o` stay 0, regardless of lock.
- R10: A high `arm_i` while already armed has no effect: the count continues and the shot proceeds unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Arm request for a new shot |
| lock_i | input | 1 | Phase-lock indication |
| permit_i | input | 1 | Fire permit; fire passes only while high |
| veto_i | input | 1 | Safety veto; forces fire low in the same cycle |
| lock_now_o | output | 1 | Qualified lock this cycle (combinational) |
| fire_o | output | 1 | One-cycle fire strobe (combinational) |
| done_o | output | 1 | Shot spent; stays set until re-arm or reset |
| count_o | output | CNT_W | Current consecutive-lock count |

## Verification
`fire_o` and `lock_now_o` depend on the inputs of the current cycle, so each one is due in the same cycle as its stimulus. `count_o` and `done_o` are registered and move one edge after the stimulus that changes them; arming becomes visible as counting only in the cycle after `arm_i`. The bench drives inputs just after the falling edge. Alongside the stimulus it queues the values a requirement-level model predicts for that cycle, and a monitor pops and compares them 4 ns later, before the rising edge. Each qualifying lock cycle is therefore checked in the cycle it occurs, and each registered consequence is checked in the next queued cycle.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    SHOT_IDLE  = 2'd0,
    SHOT_ARMED = 2'd1,
    SHOT_DONE  = 2'd2
  } shot_t;

  function automatic int cnt_width(input int hold);
    return (hold < 1) ? 1 : $clog2(hold + 1);
  endfunction
endpackage

// File: rtl/lock_qualifier.sv
module lock_qualifier #(
  parameter int HOLD = 4,
  parameter int CW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          armed,
  input  logic          lock,
  input  logic          veto,
  input  logic          fire,
  output logic [CW-1:0] count,
  output logic          qualified
);
  localparam logic [CW-1:0] SAT  = CW'(HOLD);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q;

  // qualifies on the HOLD-th consecutive locked cycle
  assign qualified = armed && lock && (cnt_q >= LAST);
  assign count     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!armed || !lock || veto || fire) begin
      cnt_q <= '0;
    end else if (cnt_q < SAT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/shot_latch.sv
module shot_latch
  import trig_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic fire,
  output logic armed,
  output logic done
);
  shot_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SHOT_ARMED: if (fire) st_d = SHOT_DONE;
      SHOT_IDLE,
      SHOT_DONE:  if (arm)  st_d = SHOT_ARMED;
      default:    st_d = SHOT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= SHOT_IDLE;
    else     st_q <= st_d;
  end

  assign armed = (st_q == SHOT_ARMED);
  assign done  = (st_q == SHOT_DONE);
endmodule

// File: rtl/veto_lane.sv
module veto_lane (
  input  logic request,
  input  logic permit,
  input  logic veto,
  output logic fire
);
  // stateless, subtractive: never raises fire on its own
  assign fire = request & permit & ~veto;
endmodule

// File: rtl/shot_trigger.sv
module shot_trigger #(
  parameter int LOCK_HOLD_CYCLES = 4,
  localparam int CNT_W = trig_pkg::cnt_width(LOCK_HOLD_CYCLES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_i,
  input  logic             lock_i,
  input  logic             permit_i,
  input  logic             veto_i,
  output logic             lock_now_o,
  output logic             fire_o,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);
  logic armed;
  logic qualified;
  logic fire;

  shot_latch u_latch (
    .clk   (clk),
    .rst   (rst),
    .arm   (arm_i),
    .fire  (fire),
    .armed (armed),
    .done  (done_o)
  );

  lock_qualifier #(.HOLD(LOCK_HOLD_CYCLES), .CW(CNT_W)) u_qual (
    .clk       (clk),
    .rst       (rst),
    .armed     (armed),
    .lock      (lock_i),
    .veto      (veto_i),
    .fire      (fire),
    .count     (count_o),
    .qualified (qualified)
  );

  veto_lane u_veto (
    .request (qualified),
    .permit  (permit_i),
    .veto    (veto_i),
    .fire    (fire)
  );

  assign lock_now_o = qualified;
  assign fire_o     = fire;
endmodule

// File: rtl/shot_trigger_chk.sv
module shot_trigger_chk #(
  parameter int HOLD = 4,
  parameter int CW   = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          arm_i,
  input logic          lock_i,
  input logic          permit_i,
  input logic          veto_i,
  input logic          fire_o,
  input logic          done_o,
  input logic [CW-1:0] count_o
);
  // R5
  veto_dominates_chk: assert property (@(posedge clk) disable iff (rst)
    veto_i |-> !fire_o);
  // R6
  permit_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !permit_i |-> !fire_o);
  // R7
  single_shot_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !fire_o);
  // R7
  fire_sets_done_chk: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> done_o);
  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    int'(count_o) <= HOLD);
  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (count_o != '0) |-> ((count_o == $past(count_o) + 1'b1) || (count_o == $past(count_o))));
  // R4
  break_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !lock_i |=> (count_o == '0));

  generate
    if (HOLD > 1) begin : g_run
      // R2
      fire_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        fire_o |-> ($past(lock_i) && !$past(veto_i)));
    end
  endgenerate

  wire unused_ok = arm_i;
endmodule

bind shot_trigger shot_trigger_chk #(.HOLD(LOCK_HOLD_CYCLES), .CW(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .arm_i    (arm_i),
  .lock_i   (lock_i),
  .permit_i (permit_i),
  .veto_i   (veto_i),
  .fire_o   (fire_o),
  .done_o   (done_o),
  .count_o  (count_o)
);

// File: tb/test_shot_trigger.sv
module test_shot_trigger;
  localparam int HOLD = 4;
  localparam int CW   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm = 1'b0, lock = 1'b0, permit = 1'b0, veto = 1'b0;
  logic lock_now, fire, done;
  logic [CW-1:0] count;

  always #5 clk = ~clk;

  shot_trigger #(.LOCK_HOLD_CYCLES(HOLD)) i_shot_trigger (
    .clk(clk), .rst(rst), .arm_i(arm), .lock_i(lock), .permit_i(permit),
    .veto_i(veto), .lock_now_o(lock_now), .fire_o(fire), .done_o(done),
    .count_o(count)
  );

  typedef struct {
    logic          ln;
    logic          f;
    logic          d;
    logic [CW-1:0] c;
    string         tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  int m_st  = 0;   // 0 idle, 1 armed, 2 done
  int m_cnt = 0;

  task automatic step(input logic a, input logic l, input logic p,
                      input logic v, input string tag);
    exp_t e;
    bit en, ln, f;
    @(negedge clk);
    rst = 1'b0; arm = a; lock = l; permit = p; veto = v;
    en = (m_st == 1);
    ln = en && l && (m_cnt >= HOLD - 1);
    f  = ln && p && !v;
    e.ln = ln; e.f = f; e.d = (m_st == 2); e.c = CW'(m_cnt); e.tag = tag;
    q.push_back(e);
    if (!en || !l || v || f) m_cnt = 0;
    else if (m_cnt < HOLD)   m_cnt = m_cnt + 1;
    if (m_st == 1) begin
      if (f) m_st = 2;
    end else if (a) m_st = 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; arm = 0; lock = 0; permit = 1; veto = 0;
    m_st = 0; m_cnt = 0;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #4;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (lock_now !== e.ln || fire !== e.f || done !== e.d || count !== e.c) begin
          fails++;
          $display("FAIL %s: got ln=%0b fire=%0b done=%0b cnt=%0d exp ln=%0b fire=%0b done=%0b cnt=%0d",
                   e.tag, lock_now, fire, done, count, e.ln, e.f, e.d, e.c);
        end
      end
    end
  end

  initial begin : watchdog
    #1_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    do_reset();
    // R1 / R9: after reset, unarmed, lock ignored
    step(0, 1, 1, 0, "R1");
    repeat (3) step(0, 1, 1, 0, "R9");
    // R8: arm from idle
    step(1, 0, 1, 0, "R8");
    // R3: one short, then break
    repeat (3) step(0, 1, 1, 0, "R3");
    step(0, 0, 1, 0, "R3");
    // R4: toggling mid-run
    step(0, 1, 1, 0, "R4");
    step(0, 1, 1, 0, "R4");
    step(0, 0, 1, 0, "R4");
    step(0, 1, 1, 0, "R4");
    step(0, 0, 1, 0, "R4");
    // R2: exact-length run
    repeat (4) step(0, 1, 1, 0, "R2");
    // R7: second run after fire
    repeat (7) step(0, 1, 1, 0, "R7");
    // R8: re-arm after done
    step(1, 0, 1, 0, "R8");
    step(0, 0, 1, 0, "R8");
    // R5: veto on the fire cycle, then fresh run needed
    repeat (3) step(0, 1, 1, 0, "R5");
    step(0, 1, 1, 1, "R5");
    repeat (4) step(0, 1, 1, 0, "R5");
    // R6: permit low saturates, permit high fires
    step(1, 0, 1, 0, "R8");
    repeat (6) step(0, 1, 0, 0, "R6");
    step(0, 1, 1, 0, "R6");
    step(0, 0, 1, 0, "R7");
    // R10: arm while armed ignored
    step(1, 0, 1, 0, "R8");
    step(0, 1, 1, 0, "R10");
    step(0, 1, 1, 0, "R10");
    step(1, 1, 1, 0, "R10");
    step(0, 1, 1, 0, "R10");
    step(0, 0, 1, 0, "R10");
    // R1: reset mid-run
    step(1, 0, 1, 0, "R8");
    step(0, 1, 1, 0, "R1");
    step(0, 1, 1, 0, "R1");
    do_reset();
    repeat (5) step(0, 1, 1, 0, "R1");
    // drain
    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule